// File: doc/BRIEF.md
# Size-Tagged Register File with Read-Side Masking

This block is a 64-bit general register file in which every entry carries a 2-bit chunk-size tag next to its data. A write stores the result as produced, all 64 bits, and records the operand size of the producing operation in the tag; a SIMD write always records the full 64-bit size. Zero extension is not applied on the write path. It happens on the way out: each read port looks up the tag of the addressed entry and clears every bit above the recorded size before the operand is handed on. Each read port therefore has its own masking stage.

Because the stored value may be wider than its tag allows, forwarding a result straight from an execution unit into a consumer that wants a wider operand would show bits that the register file would have cleared. The block therefore keeps a per-register in-flight flag and a pending size for results that have been issued but not yet written. Each read port raises a hazard when it asks for an operand wider than the pending size of an in-flight result. The consumer must then hold until the write lands. A write in the same cycle as a read is seen by that read, for both data and tag.

Top module: `rf_sized_regfile`

## Requirements
- R1: After reset every register holds zero with tag 11 (64-bit), and a read of any register returns data 0 with `rd_size_o` = 11. Before any read, the read outputs also show 0 and 11.
- R2: `rd_data_o[p]` and `rd_size_o[p]` are updated at the clock edge that samples `rd_en_i[p]` high, so they are valid one cycle after the request. They hold their value in every cycle in which `rd_en_i[p]` is low.
- R3: The tag encoding is 00 = 8, 01 = 16, 10 = 32 and 11 = 64 bits. A non-SIMD write stores `wr_size_i` as the tag. A read returns the stored data with bits [63:8], [63:16] or [63:32] cleared for tags 00, 01 and 10, and no bits cleared for tag 11. `rd_size_o` reports the tag.
- R4: A write with `wr_simd_i` high stores tag 11 whatever `wr_size_i` is, and a later read returns all 64 bits.
- R5: The three read ports work independently. Each masks its own operand with the tag of the register it addresses, and all three may read in the same cycle.
- R6: A read of a register that is written in the same cycle returns the new data, masked by the new tag, and reports the new tag.
- R7: When several write ports write the same register in one cycle, the port with the highest index sets both the data and the tag.
- R8: `rd_hazard_o[p]` is combinational. It is high when all of the following hold: `rd_en_i[p]` is high, the addressed register is in flight, the requested size `rd_size_i[p]` (same encoding as R3) is larger than that register's pending size, and no write to that register occurs in the current cycle.
- R9: An issue (`iss_en_i`) marks its register in flight with pending size `iss_size_i`, or 11 when `iss_simd_i` is high. The mark is visible from the next cycle. A write to the register clears the mark. When an issue and a write hit the same register in the same cycle, the issue wins.
- R10: `rd_hazard_o[p]` stays low when `rd_en_i[p]` is low, when the requested size is 00, or when the register is not in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | NWR | Write enable per write port |
| wr_addr_i | input | NWR x AW | Write register index per port |
| wr_data_i | input | NWR x 64 | Full-width result per port |
| wr_size_i | input | NWR x 2 | Operand size of the producing operation |
| wr_simd_i | input | NWR | Producing operation was SIMD (forces tag 11) |
| iss_en_i | input | 1 | Marks a result as in flight |
| iss_addr_i | input | AW | Destination register of the issued result |
| iss_size_i | input | 2 | Operand size of the issued result |
| iss_simd_i | input | 1 | Issued operation is SIMD |
| rd_en_i | input | NRD | Read request per read port |
| rd_addr_i | input | NRD x AW | Read register index per port |
| rd_size_i | input | NRD x 2 | Operand size the consumer requests |
| rd_data_o | output | NRD x 64 | Masked operand, one cycle after request |
| rd_size_o | output | NRD x 2 | Tag of the operand delivered |
| rd_hazard_o | output | NRD | Consumer must wait for the write |

## Verification
The hazard outputs are combinational, so the bench compares them one time step after driving a request, in the same cycle, before the clock edge. Read data and size are registered and due one edge after the request. The driver pushes each expectation tagged with that due cycle, and the monitor compares it at the following falling edge. The monitor also compares every port in every cycle, so a port without a request must still show its previous value. The expected values come from a bench model of data, tags and in-flight state, which is updated only after the edge at which the design itself commits the writes and issues.

// File: rtl/rf_sz_pkg.sv
package rf_sz_pkg;
  localparam int unsigned DATA_W = 64;

  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } chunk_sz_e;

  // thermometer mask: each larger size enables one more band
  function automatic logic [DATA_W-1:0] chunk_mask(input logic [1:0] sz);
    logic [DATA_W-1:0] m;
    m        = '0;
    m[7:0]   = '1;
    if (sz != SZ_8)  m[15:8]  = '1;
    if (sz[1])       m[31:16] = '1;
    if (sz == SZ_64) m[63:32] = '1;
    return m;
  endfunction

  function automatic logic [1:0] eff_tag(input logic [1:0] sz, input logic simd);
    return simd ? SZ_64 : sz;
  endfunction
endpackage

// File: rtl/rf_store.sv
module rf_store
  import rf_sz_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned NWR   = 2,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NWR-1:0]                    wr_en_i,
  input  logic [NWR-1:0][AW-1:0]            wr_addr_i,
  input  logic [NWR-1:0][DATA_W-1:0]        wr_data_i,
  input  logic [NWR-1:0][1:0]               wr_tag_i,
  output logic [NREGS-1:0][DATA_W-1:0]      reg_data_o,
  output logic [NREGS-1:0][1:0]             reg_tag_o
);

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] nxt_data;
    logic [1:0]        nxt_tag;

    // ascending scan: highest-index matching port wins
    always_comb begin
      hit      = 1'b0;
      nxt_data = reg_data_o[r];
      nxt_tag  = reg_tag_o[r];
      for (int k = 0; k < NWR; k++) begin
        if (wr_en_i[k] && (wr_addr_i[k] == AW'(r))) begin
          hit      = 1'b1;
          nxt_data = wr_data_i[k];
          nxt_tag  = wr_tag_i[k];
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_data_o[r] <= '0;
        reg_tag_o[r]  <= SZ_64;
      end else if (hit) begin
        reg_data_o[r] <= nxt_data;
        reg_tag_o[r]  <= nxt_tag;
      end
    end
  end

  AST_TOP_PORT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[NWR-1] |=> (reg_tag_o[$past(wr_addr_i[NWR-1])] == $past(wr_tag_i[NWR-1]))
                    && (reg_data_o[$past(wr_addr_i[NWR-1])] == $past(wr_data_i[NWR-1]))); // R7

endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
  import rf_sz_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned NWR   = 2,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_en_i,
  input  logic [AW-1:0]                 rd_addr_i,
  input  logic [NREGS-1:0][DATA_W-1:0]  reg_data_i,
  input  logic [NREGS-1:0][1:0]         reg_tag_i,
  input  logic [NWR-1:0]                wr_en_i,
  input  logic [NWR-1:0][AW-1:0]        wr_addr_i,
  input  logic [NWR-1:0][DATA_W-1:0]    wr_data_i,
  input  logic [NWR-1:0][1:0]           wr_tag_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic [1:0]                    rd_size_o
);

  logic [DATA_W-1:0] raw_data;
  logic [1:0]        raw_tag;

  // write-first: same-cycle write overrides stored entry
  always_comb begin
    raw_data = reg_data_i[rd_addr_i];
    raw_tag  = reg_tag_i[rd_addr_i];
    for (int k = 0; k < NWR; k++) begin
      if (wr_en_i[k] && (wr_addr_i[k] == rd_addr_i)) begin
        raw_data = wr_data_i[k];
        raw_tag  = wr_tag_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      rd_size_o <= SZ_64;
    end else if (rd_en_i) begin
      rd_data_o <= raw_data & chunk_mask(raw_tag);
      rd_size_o <= raw_tag;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o) && $stable(rd_size_o)); // R2

  AST_RD_HIGH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~chunk_mask(rd_size_o)) == '0); // R3

  AST_RD_WRITE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && wr_en_i[NWR-1] && (wr_addr_i[NWR-1] == rd_addr_i)
    |=> (rd_size_o == $past(wr_tag_i[NWR-1]))
        && (rd_data_o == ($past(wr_data_i[NWR-1]) & chunk_mask(rd_size_o)))); // R6

endmodule

// File: rtl/rf_inflight.sv
module rf_inflight
  import rf_sz_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned NWR   = 2,
  parameter int unsigned NRD   = 3,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NWR-1:0]         wr_en_i,
  input  logic [NWR-1:0][AW-1:0] wr_addr_i,
  input  logic                   iss_en_i,
  input  logic [AW-1:0]          iss_addr_i,
  input  logic [1:0]             iss_tag_i,
  input  logic [NRD-1:0]         rd_en_i,
  input  logic [NRD-1:0][AW-1:0] rd_addr_i,
  input  logic [NRD-1:0][1:0]    rd_size_i,
  output logic [NRD-1:0]         rd_hazard_o
);

  logic [NREGS-1:0]      infl_q;
  logic [NREGS-1:0][1:0] ptag_q;

  for (genvar r = 0; r < NREGS; r++) begin : g_ent
    logic wr_hit;
    logic iss_hit;

    always_comb begin
      wr_hit = 1'b0;
      for (int k = 0; k < NWR; k++)
        if (wr_en_i[k] && (wr_addr_i[k] == AW'(r))) wr_hit = 1'b1;
    end
    assign iss_hit = iss_en_i && (iss_addr_i == AW'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        infl_q[r] <= 1'b0;
        ptag_q[r] <= SZ_64;
      end else if (iss_hit) begin
        infl_q[r] <= 1'b1;
        ptag_q[r] <= iss_tag_i;
      end else if (wr_hit) begin
        infl_q[r] <= 1'b0;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_haz
    logic landing;
    always_comb begin
      landing = 1'b0;
      for (int k = 0; k < NWR; k++)
        if (wr_en_i[k] && (wr_addr_i[k] == rd_addr_i[p])) landing = 1'b1;
    end
    assign rd_hazard_o[p] = rd_en_i[p] && infl_q[rd_addr_i[p]] && !landing
                            && (rd_size_i[p] > ptag_q[rd_addr_i[p]]);

    AST_HAZ_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_hazard_o[p] |-> rd_en_i[p] && (rd_size_i[p] != SZ_8)); // R10
  end

  AST_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[0] && !(iss_en_i && (iss_addr_i == wr_addr_i[0]))
    |=> !infl_q[$past(wr_addr_i[0])]); // R9

  AST_ISSUE_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_en_i |=> infl_q[$past(iss_addr_i)] && (ptag_q[$past(iss_addr_i)] == $past(iss_tag_i))); // R9

endmodule

// File: rtl/rf_sized_regfile.sv
module rf_sized_regfile
  import rf_sz_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned NWR   = 2,
  parameter int unsigned NRD   = 3,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NWR-1:0]                 wr_en_i,
  input  logic [NWR-1:0][AW-1:0]         wr_addr_i,
  input  logic [NWR-1:0][DATA_W-1:0]     wr_data_i,
  input  logic [NWR-1:0][1:0]            wr_size_i,
  input  logic [NWR-1:0]                 wr_simd_i,
  input  logic                           iss_en_i,
  input  logic [AW-1:0]                  iss_addr_i,
  input  logic [1:0]                     iss_size_i,
  input  logic                           iss_simd_i,
  input  logic [NRD-1:0]                 rd_en_i,
  input  logic [NRD-1:0][AW-1:0]         rd_addr_i,
  input  logic [NRD-1:0][1:0]            rd_size_i,
  output logic [NRD-1:0][DATA_W-1:0]     rd_data_o,
  output logic [NRD-1:0][1:0]            rd_size_o,
  output logic [NRD-1:0]                 rd_hazard_o
);

  logic [NWR-1:0][1:0]             wr_tag;
  logic [NREGS-1:0][DATA_W-1:0]    reg_data;
  logic [NREGS-1:0][1:0]           reg_tag;
  logic [1:0]                      iss_tag;

  for (genvar k = 0; k < NWR; k++) begin : g_wtag
    assign wr_tag[k] = eff_tag(wr_size_i[k], wr_simd_i[k]);
  end
  assign iss_tag = eff_tag(iss_size_i, iss_simd_i);

  rf_store #(.NREGS(NREGS), .NWR(NWR)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .wr_tag_i   (wr_tag),
    .reg_data_o (reg_data),
    .reg_tag_o  (reg_tag)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_rd_port #(.NREGS(NREGS), .NWR(NWR)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_en_i    (rd_en_i[p]),
      .rd_addr_i  (rd_addr_i[p]),
      .reg_data_i (reg_data),
      .reg_tag_i  (reg_tag),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .wr_tag_i   (wr_tag),
      .rd_data_o  (rd_data_o[p]),
      .rd_size_o  (rd_size_o[p])
    );
  end

  rf_inflight #(.NREGS(NREGS), .NWR(NWR), .NRD(NRD)) u_infl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .iss_en_i    (iss_en_i),
    .iss_addr_i  (iss_addr_i),
    .iss_tag_i   (iss_tag),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .rd_size_i   (rd_size_i),
    .rd_hazard_o (rd_hazard_o)
  );

  AST_SIMD_FULL_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[NWR-1] && wr_simd_i[NWR-1] |=> reg_tag[$past(wr_addr_i[NWR-1])] == SZ_64); // R4

endmodule

// File: tb/rf_sized_regfile_tb.sv
module rf_sized_regfile_tb;
  localparam int NREGS = 32;
  localparam int NWR   = 2;
  localparam int NRD   = 3;
  localparam int AW    = 5;

  typedef struct {
    int          due;
    int          port;
    logic [63:0] data;
    logic [1:0]  sz;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NWR-1:0]            wr_en;
  logic [NWR-1:0][AW-1:0]    wr_addr;
  logic [NWR-1:0][63:0]      wr_data;
  logic [NWR-1:0][1:0]       wr_size;
  logic [NWR-1:0]            wr_simd;
  logic                      iss_en;
  logic [AW-1:0]             iss_addr;
  logic [1:0]                iss_size;
  logic                      iss_simd;
  logic [NRD-1:0]            rd_en;
  logic [NRD-1:0][AW-1:0]    rd_addr;
  logic [NRD-1:0][1:0]       rd_size;
  logic [NRD-1:0][63:0]      rd_data;
  logic [NRD-1:0][1:0]       rd_sz_o;
  logic [NRD-1:0]            rd_haz;

  rf_sized_regfile #(.NREGS(NREGS), .NWR(NWR), .NRD(NRD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_size_i(wr_size), .wr_simd_i(wr_simd),
    .iss_en_i(iss_en), .iss_addr_i(iss_addr), .iss_size_i(iss_size), .iss_simd_i(iss_simd),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_size_i(rd_size),
    .rd_data_o(rd_data), .rd_size_o(rd_sz_o), .rd_hazard_o(rd_haz)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  exp_t q[$];

  logic [63:0] m_data [NREGS];
  logic [1:0]  m_tag  [NREGS];
  logic        m_infl [NREGS];
  logic [1:0]  m_ptag [NREGS];
  logic [63:0] last_d [NRD];
  logic [1:0]  last_s [NRD];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] keep_bits(input logic [1:0] t);
    case (t)
      2'b00:   return 64'h0000_0000_0000_00FF;
      2'b01:   return 64'h0000_0000_0000_FFFF;
      2'b10:   return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  task automatic clr_in();
    wr_en = '0; wr_addr = '0; wr_data = '0; wr_size = '0; wr_simd = '0;
    iss_en = 1'b0; iss_addr = '0; iss_size = '0; iss_simd = 1'b0;
    rd_en = '0; rd_addr = '0; rd_size = '0;
  endtask

  task automatic set_wr(input int k, input int a, input logic [63:0] d,
                        input logic [1:0] s, input logic simd);
    wr_en[k] = 1'b1; wr_addr[k] = AW'(a); wr_data[k] = d; wr_size[k] = s; wr_simd[k] = simd;
  endtask

  task automatic set_rd(input int p, input int a, input logic [1:0] s);
    rd_en[p] = 1'b1; rd_addr[p] = AW'(a); rd_size[p] = s;
  endtask

  task automatic set_iss(input int a, input logic [1:0] s, input logic simd);
    iss_en = 1'b1; iss_addr = AW'(a); iss_size = s; iss_simd = simd;
  endtask

  // drive is already applied; check hazards now, queue reads, advance one cycle
  task automatic step(input string req);
    #1;
    for (int p = 0; p < NRD; p++) begin
      logic land, exp_h;
      logic [63:0] d;
      logic [1:0] t;
      land = 1'b0;
      d = m_data[rd_addr[p]];
      t = m_tag[rd_addr[p]];
      for (int k = 0; k < NWR; k++)
        if (wr_en[k] && wr_addr[k] == rd_addr[p]) begin
          land = 1'b1; d = wr_data[k]; t = wr_simd[k] ? 2'b11 : wr_size[k];
        end
      exp_h = rd_en[p] && m_infl[rd_addr[p]] && !land && (rd_size[p] > m_ptag[rd_addr[p]]);
      n_cmp++;
      if (rd_haz[p] !== exp_h) begin
        n_bad++;
        $display("FAIL %s/R8 hazard port %0d: actual %b expected %b", req, p, rd_haz[p], exp_h);
      end
      if (rd_en[p]) begin
        last_d[p] = d & keep_bits(t);
        last_s[p] = t;
      end
      q.push_back('{due: cyc + 1, port: p, data: last_d[p], sz: last_s[p],
                    req: rd_en[p] ? req : "R2"});
    end
    @(posedge clk);
    for (int k = 0; k < NWR; k++)
      if (wr_en[k]) begin
        m_data[wr_addr[k]] = wr_data[k];
        m_tag[wr_addr[k]]  = wr_simd[k] ? 2'b11 : wr_size[k];
        m_infl[wr_addr[k]] = 1'b0;
      end
    if (iss_en) begin
      m_infl[iss_addr] = 1'b1;
      m_ptag[iss_addr] = iss_simd ? 2'b11 : iss_size;
    end
    @(negedge clk);
    clr_in();
  endtask

  // monitor: compare registered read results at the negedge they are due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (rd_data[e.port] !== e.data || rd_sz_o[e.port] !== e.sz) begin
        n_bad++;
        $display("FAIL %s port %0d: actual %h/%b expected %h/%b",
                 e.req, e.port, rd_data[e.port], rd_sz_o[e.port], e.data, e.sz);
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clr_in();
    for (int r = 0; r < NREGS; r++) begin
      m_data[r] = '0; m_tag[r] = 2'b11; m_infl[r] = 1'b0; m_ptag[r] = 2'b11;
    end
    for (int p = 0; p < NRD; p++) begin last_d[p] = '0; last_s[p] = 2'b11; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset outputs, then reads of reset registers
    step("R1");
    set_rd(0, 0, 2'b11); set_rd(1, 5, 2'b00); set_rd(2, 31, 2'b10);
    step("R1");

    // R3: each tag encoding clears its band
    set_wr(0, 1, 64'hF0E1_D2C3_B4A5_9687, 2'b00, 1'b0);
    set_wr(1, 2, 64'h1122_3344_5566_7788, 2'b01, 1'b0);
    step("R3");
    set_wr(0, 3, 64'h8877_6655_4433_2211, 2'b10, 1'b0);
    set_wr(1, 4, 64'hDEAD_BEEF_CAFE_F00D, 2'b11, 1'b0);
    set_rd(0, 1, 2'b00);
    step("R3");
    // R5: three ports, three different tags, same cycle
    set_rd(0, 2, 2'b01); set_rd(1, 3, 2'b10); set_rd(2, 4, 2'b11);
    step("R5");
    step("R2");
    step("R2");

    // R4: SIMD write with small size keeps all 64 bits
    set_wr(0, 6, 64'hA5A5_5A5A_0F0F_F0F0, 2'b00, 1'b1);
    step("R4");
    set_rd(2, 6, 2'b11);
    step("R4");

    // R6: write-first on same-cycle read
    set_wr(0, 7, 64'h0123_4567_89AB_CDEF, 2'b10, 1'b0);
    set_rd(1, 7, 2'b10);
    set_rd(0, 6, 2'b11);
    step("R6");

    // R7: both write ports hit r8; port 1 wins (data and tag)
    set_wr(0, 8, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b0);
    set_wr(1, 8, 64'h7777_6666_5555_4444, 2'b01, 1'b0);
    step("R7");
    set_rd(0, 8, 2'b11);
    step("R7");

    // R8/R10: in-flight 16-bit result on r9
    set_iss(9, 2'b01, 1'b0);
    set_rd(0, 9, 2'b11);          // issue not yet visible: R9
    step("R9");
    set_rd(0, 9, 2'b10); set_rd(1, 9, 2'b01); set_rd(2, 9, 2'b00);
    step("R8");
    rd_size[0] = 2'b11;           // rd_en low: no hazard
    step("R10");
    // R9: the landing write clears the hazard in the same cycle
    set_wr(1, 9, 64'h0000_1111_2222_3333, 2'b01, 1'b0);
    set_rd(0, 9, 2'b11);
    step("R9");
    set_rd(0, 9, 2'b11);
    step("R9");

    // R9: SIMD issue never hazards; issue beats same-cycle write
    set_iss(10, 2'b00, 1'b1);
    step("R9");
    set_rd(1, 10, 2'b11);
    step("R9");
    set_iss(11, 2'b00, 1'b0);
    set_wr(0, 11, 64'h55, 2'b00, 1'b0);
    step("R9");
    set_rd(2, 11, 2'b01);
    step("R9");
    set_rd(0, 12, 2'b11);         // not in flight: R10
    step("R10");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      for (int k = 0; k < NWR; k++)
        if ($urandom_range(1, 0) == 1)
          set_wr(k, $urandom_range(7, 0), {$urandom, $urandom},
                 2'($urandom_range(3, 0)), $urandom_range(3, 0) == 0);
      if ($urandom_range(2, 0) == 0)
        set_iss($urandom_range(7, 0), 2'($urandom_range(3, 0)), $urandom_range(3, 0) == 0);
      for (int p = 0; p < NRD; p++)
        if ($urandom_range(2, 0) != 0)
          set_rd(p, $urandom_range(7, 0), 2'($urandom_range(3, 0)));
      step("R5");
    end
    step("R2");
    step("R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule